// File: doc/BRIEF.md
# NAND Flash Bus Interface Controller

This block connects a 32-bit host register bus to an 8-bit NAND flash device. Software steers the flash control lines (command latch, address latch, chip enable with a choice of four selects, and a gate for data writes) through a mode register. Each access to the data register turns into a single timed strobe on the flash pins: a write strobe that drives the low data byte, or a read strobe that samples the device byte and returns it.

The strobe stays low for a programmable number of bus clocks and is followed by a programmable hold phase. Through both phases the register bus is held off by a request/acknowledge handshake. A status register reports the device ready/busy line after synchronisation. A self-clearing soft-reset bit puts the mode and timing registers back to their defaults. Register offsets are byte addresses on a 5-bit bus address: data 0x00, mode 0x04, status 0x08, timing 0x14, soft reset 0x18.

Top module: `nfc_ctrl`

## Requirements
- R1: After reset, the mode register reads 0, the timing register reads 0xFF, status and soft-reset read 0, every `nand_ce_n` bit is high, both strobes are high and `nand_dq_oe` is low.
- R2: Mode register (0x04) fields are: bit 0 drives `nand_cle`, bit 1 drives `nand_ale`, bits 3:2 pick a select, bit 4 enables the chip and bit 7 gates data writes. Bits 6:5 and 31:8 read 0. With bit 4 set, only `nand_ce_n[sel]` is low; with bit 4 clear, all are high.
- R3: When permitted, a write to the data register (0x00) drives byte [7:0] on `nand_dq_o` with `nand_dq_oe` high. `nand_we_n` goes low for SPW+1 clocks, then the byte stays driven for HOLD+2 more clocks, and `bus_ack` follows SPW+HOLD+4 clocks after the request is taken.
- R4: A read of the data register pulses `nand_re_n` low for SPW+1 clocks and samples `nand_dq_i` in the last low clock. It returns that byte zero-extended, with `bus_ack` SPW+HOLD+4 clocks after the request.
- R5: The timing register (0x14) holds HOLD in bits 7:4 and SPW in bits 3:0. Bits 31:8 read 0.
- R6: A data write while mode bits 7, 1 and 0 are all clear produces no strobe and is acknowledged one clock after the request. Setting CLE alone is enough to permit the write.
- R7: Status (0x08) bit 7 reads 1 while `nand_rb_n` is low, after a two-flop synchroniser. All other status bits read 0.
- R8: Writing 1 to bit 0 of the soft-reset register (0x18) restores the mode and timing defaults. That bit reads 1 for 4 clocks and then 0. Register writes in that window are dropped, and a data access waits until the window ends.
- R9: `bus_ack` is a one-clock pulse. A register access is acknowledged the clock after it is taken, and no data access starts before the previous one is acknowledged.
- R10: Offsets other than the five listed (including 0x0C and 0x10) read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-clock completion pulse |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data driven to the flash |
| nand_dq_oe | output | 1 | Output enable for `nand_dq_o` |
| nand_dq_i | input | 8 | Data from the flash |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The bench measures strobe and hold lengths at several timing settings, including zero counts, where an off-by-one counter would shorten or stretch the pulse by a clock and shift the acknowledge. It checks that a data write with the gate and both latch bits clear leaves the write strobe quiet, where a design that ignored the gate would emit a pulse. It issues writes and a data read while the soft-reset bit is still set: a design that accepted them early would keep the written mode value or strobe with stale timing, and the stall shows up as a fixed acknowledge delay.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int NFC_BUS_W  = 32;
  localparam int NFC_ADDR_W = 5;
  localparam int NFC_NUM_CS = 4;
  localparam int NFC_SEL_W  = $clog2(NFC_NUM_CS);
  localparam int NFC_BYTE_W = 8;
  localparam int NFC_CNT_W  = 5;   // holds up to 17 phase clocks

  localparam logic [NFC_ADDR_W-1:0] OFS_DATA = 5'h00;
  localparam logic [NFC_ADDR_W-1:0] OFS_MODE = 5'h04;
  localparam logic [NFC_ADDR_W-1:0] OFS_STAT = 5'h08;
  localparam logic [NFC_ADDR_W-1:0] OFS_TIME = 5'h14;
  localparam logic [NFC_ADDR_W-1:0] OFS_SRST = 5'h18;

  localparam int STAT_BUSY_BIT = 7;

  typedef struct packed {
    logic                 wgate;
    logic                 ce;
    logic [NFC_SEL_W-1:0] sel;
    logic                 ale;
    logic                 cle;
  } mode_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_STRB, SQ_HOLD, SQ_ACK} seq_st_t;

  // strobe low time in bus clocks
  function automatic logic [NFC_CNT_W-1:0] strobe_cycles(input logic [3:0] spw);
    return {1'b0, spw} + 5'd1;
  endfunction

  // hold phase length in bus clocks
  function automatic logic [NFC_CNT_W-1:0] hold_cycles(input logic [3:0] hold);
    return {1'b0, hold} + 5'd2;
  endfunction

  function automatic logic [7:0] pack_mode(input mode_t m);
    return {m.wgate, 2'b00, m.ce, m.sel, m.ale, m.cle};
  endfunction

  function automatic mode_t unpack_mode(input logic [7:0] b);
    mode_t m;
    m.wgate = b[7];
    m.ce    = b[4];
    m.sel   = b[3:2];
    m.ale   = b[1];
    m.cle   = b[0];
    return m;
  endfunction
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= {STAGES{RST_VAL}};
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int BUS_W      = NFC_BUS_W,
  parameter int RST_CYCLES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [NFC_ADDR_W-1:0] addr,
  input  logic [7:0]            wbyte,
  input  logic                  busy_in,
  output logic [BUS_W-1:0]      rdata,
  output mode_t                 mode,
  output logic [3:0]            spw,
  output logic [3:0]            hold,
  output logic                  srst_busy,
  output logic                  srst_start
);
  localparam int RC_W = $clog2(RST_CYCLES + 1);

  mode_t           mode_q;
  logic [7:0]      timing_q;
  logic [RC_W-1:0] rst_cnt;

  assign srst_start = wr_en && (addr == OFS_SRST) && wbyte[0];
  assign srst_busy  = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      timing_q <= 8'hFF;
      rst_cnt  <= '0;
    end else begin
      if (srst_start)     rst_cnt <= RC_W'(RST_CYCLES);
      else if (srst_busy) rst_cnt <= rst_cnt - RC_W'(1);

      if (srst_start || srst_busy) begin
        mode_q   <= '0;
        timing_q <= 8'hFF;
      end else if (wr_en && addr == OFS_MODE) begin
        mode_q <= unpack_mode(wbyte);
      end else if (wr_en && addr == OFS_TIME) begin
        timing_q <= wbyte;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MODE: rdata[7:0]           = pack_mode(mode_q);
      OFS_STAT: rdata[STAT_BUSY_BIT] = busy_in;
      OFS_TIME: rdata[7:0]           = timing_q;
      OFS_SRST: rdata[0]             = srst_busy;
      default:  ;
    endcase
  end

  assign mode = mode_q;
  assign spw  = timing_q[3:0];
  assign hold = timing_q[7:4];
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req,
  input  logic                  wr,
  input  logic                  is_data,
  input  logic                  wr_allowed,
  input  logic                  stall,
  input  logic [3:0]            spw,
  input  logic [3:0]            hold,
  input  logic [NFC_BYTE_W-1:0] wbyte,
  output logic                  take,
  output logic                  launch,
  output logic                  rd_capture,
  output logic                  ack,
  output logic                  we_n,
  output logic                  re_n,
  output logic [NFC_BYTE_W-1:0] dq_o,
  output logic                  dq_oe
);
  seq_st_t               st;
  logic [NFC_CNT_W-1:0]  cnt;
  logic                  dir_wr;
  logic [NFC_BYTE_W-1:0] byte_q;

  assign take       = (st == SQ_IDLE) && req && (!is_data || !stall);
  assign launch     = take && is_data && (!wr || wr_allowed);
  assign rd_capture = (st == SQ_STRB) && (cnt == '0) && !dir_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      dir_wr <= 1'b0;
      byte_q <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (launch) begin
            st     <= SQ_STRB;
            cnt    <= strobe_cycles(spw) - 5'd1;
            dir_wr <= wr;
            byte_q <= wbyte;
          end else if (take) begin
            st <= SQ_ACK;
          end
        end
        SQ_STRB: begin
          if (cnt == '0) begin
            st  <= SQ_HOLD;
            cnt <= hold_cycles(hold) - 5'd1;
          end else begin
            cnt <= cnt - 5'd1;
          end
        end
        SQ_HOLD: begin
          if (cnt == '0) st <= SQ_ACK;
          else           cnt <= cnt - 5'd1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign ack   = (st == SQ_ACK);
  assign we_n  = !((st == SQ_STRB) && dir_wr);
  assign re_n  = !((st == SQ_STRB) && !dir_wr);
  assign dq_oe = dir_wr && ((st == SQ_STRB) || (st == SQ_HOLD));
  assign dq_o  = byte_q;
endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int BUS_W       = NFC_BUS_W,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_req,
  input  logic                  bus_wr,
  input  logic [NFC_ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  output logic                  bus_ack,
  output logic [NFC_NUM_CS-1:0] nand_ce_n,
  output logic                  nand_cle,
  output logic                  nand_ale,
  output logic                  nand_we_n,
  output logic                  nand_re_n,
  output logic [NFC_BYTE_W-1:0] nand_dq_o,
  output logic                  nand_dq_oe,
  input  logic [NFC_BYTE_W-1:0] nand_dq_i,
  input  logic                  nand_rb_n
);
  mode_t            mode;
  logic [3:0]       spw, hold;
  logic             srst_busy, srst_start;
  logic             take, launch, rd_capture;
  logic             rb_sync, dev_busy;
  logic             is_data, reg_wr, wr_allowed;
  logic [BUS_W-1:0] reg_rdata, rdata_q;
  logic             unused_wdata_hi;

  // only the low byte of a write carries information
  assign unused_wdata_hi = ^bus_wdata[BUS_W-1:NFC_BYTE_W];

  assign is_data    = (bus_addr == OFS_DATA);
  assign reg_wr     = take && bus_wr && !is_data;
  assign wr_allowed = mode.wgate | mode.cle | mode.ale;
  assign dev_busy   = !rb_sync;

  nfc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_sync)
  );

  nfc_regs #(.BUS_W(BUS_W), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(bus_addr),
    .wbyte(bus_wdata[7:0]), .busy_in(dev_busy), .rdata(reg_rdata),
    .mode(mode), .spw(spw), .hold(hold),
    .srst_busy(srst_busy), .srst_start(srst_start)
  );

  nfc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .wr(bus_wr),
    .is_data(is_data), .wr_allowed(wr_allowed), .stall(srst_busy),
    .spw(spw), .hold(hold), .wbyte(bus_wdata[NFC_BYTE_W-1:0]),
    .take(take), .launch(launch), .rd_capture(rd_capture),
    .ack(bus_ack), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   rdata_q <= '0;
    else if (take && !is_data)    rdata_q <= reg_rdata;
    else if (take)                rdata_q <= '0;
    else if (rd_capture)          rdata_q <= {{(BUS_W-NFC_BYTE_W){1'b0}}, nand_dq_i};
  end
  assign bus_rdata = rdata_q;

  generate
    for (genvar g = 0; g < NFC_NUM_CS; g++) begin : g_ce
      assign nand_ce_n[g] = !(mode.ce && (mode.sel == NFC_SEL_W'(g)));
    end
  endgenerate

  assign nand_cle = mode.cle;
  assign nand_ale = mode.ale;
endmodule

// File: rtl/nfc_ctrl_chk.sv
module nfc_ctrl_chk
  import nfc_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_ack,
  input logic                  bus_wr,
  input logic                  take,
  input logic                  is_data,
  input logic                  wr_allowed,
  input logic                  srst_busy,
  input logic [3:0]            spw,
  input logic [NFC_NUM_CS-1:0] nand_ce_n,
  input logic                  nand_we_n,
  input logic                  nand_re_n,
  input logic                  nand_dq_oe
);
  logic                 strb_low, strb_low_q;
  logic [NFC_CNT_W-1:0] low_cnt;

  assign strb_low = !nand_we_n || !nand_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_low_q <= 1'b0;
      low_cnt    <= '0;
    end else begin
      strb_low_q <= strb_low;
      low_cnt    <= strb_low ? low_cnt + 5'd1 : '0;
    end
  end

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  a_r2_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  a_r3_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);

  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_low_q && !strb_low) |-> (low_cnt == ({1'b0, spw} + 5'd1)));

  a_r6_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_data && bus_wr && !wr_allowed) |=> (nand_we_n && bus_ack));

  a_r8_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (nand_we_n && nand_re_n));
endmodule

bind nfc_ctrl nfc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .bus_wr(bus_wr),
  .take(take), .is_data(is_data), .wr_allowed(wr_allowed),
  .srst_busy(srst_busy), .spw(spw), .nand_ce_n(nand_ce_n),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe)
);

// File: tb/tb_nfc_ctrl.sv
`timescale 1ns/1ps
module tb_nfc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ack;
  logic [3:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb_n = 1'b1;

  always #2.5 clk = ~clk;

  nfc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb_n(nand_rb_n)
  );

  localparam logic [4:0] A_DATA = 5'h00, A_MODE = 5'h04, A_STAT = 5'h08,
                         A_TIME = 5'h14, A_SRST = 5'h18;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    string       rq;
    logic [31:0] data;
    bit          chk_data;
    int          start;
    int          lat;
    int          kind;   // 0 none, 1 write strobe, 2 read strobe
    int          nw;
    int          nr;
    int          width;
    int          oelen;
    logic [7:0]  dq;
  } exp_t;

  exp_t sbq[$];
  int   exp_nw = 0, exp_nr = 0;
  int   nw_tot = 0, nr_tot = 0, wlen = 0, rlen = 0, oel = 0;
  int   last_w = 0, last_r = 0, last_oe = 0;
  logic [7:0] last_dq = '0;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // monitor: strobe measurement first, then scoreboard compare on ack
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n) begin wlen++; last_dq = nand_dq_o; end
      else if (wlen > 0) begin last_w = wlen; nw_tot++; wlen = 0; end
      if (!nand_re_n) rlen++;
      else if (rlen > 0) begin last_r = rlen; nr_tot++; rlen = 0; end
      if (nand_dq_oe) oel++;
      else if (oel > 0) begin last_oe = oel; oel = 0; end
      if (bus_ack) begin
        if (sbq.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R9 unexpected ack: actual 1 expected 0");
        end else begin
          exp_t e;
          e = sbq.pop_front();
          if (e.chk_data) check({e.rq, " data"}, bus_rdata, e.data);
          if (e.lat >= 0) check({e.rq, " latency"}, cyc - e.start, e.lat);
          check({e.rq, " write strobe count"}, nw_tot, e.nw);
          check({e.rq, " read strobe count"}, nr_tot, e.nr);
          if (e.kind == 1) begin
            check({e.rq, " we_n width"}, last_w, e.width);
            check({e.rq, " drive length"}, last_oe, e.oelen);
            check({e.rq, " byte on pins"}, {24'b0, last_dq}, {24'b0, e.dq});
          end
          if (e.kind == 2) check({e.rq, " re_n width"}, last_r, e.width);
        end
      end
    end
  end

  // driver: called at a negedge with the controller idle
  task automatic access(input string rq, input bit wr, input logic [4:0] a,
                        input logic [31:0] wd, input logic [31:0] exp_d, input bit chk,
                        input int lat, input int kind, input int width, input int oelen,
                        input logic [7:0] dq);
    exp_t e;
    if (kind == 1) exp_nw++;
    if (kind == 2) exp_nr++;
    e.rq = rq; e.data = exp_d; e.chk_data = chk; e.start = cyc; e.lat = lat;
    e.kind = kind; e.nw = exp_nw; e.nr = exp_nr; e.width = width;
    e.oelen = oelen; e.dq = dq;
    sbq.push_back(e);
    bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    do @(negedge clk); while (!bus_ack);
    bus_req = 1'b0;
    @(negedge clk);
    check({rq, " R9 ack lasts one clock"}, {31'b0, bus_ack}, 32'd0);
  endtask

  task automatic wreg(input string rq, input logic [4:0] a, input logic [31:0] d);
    access(rq, 1'b1, a, d, 32'd0, 1'b0, 1, 0, 0, 0, 8'h00);
  endtask

  task automatic rreg(input string rq, input logic [4:0] a, input logic [31:0] exp);
    access(rq, 1'b0, a, 32'd0, exp, 1'b1, 1, 0, 0, 0, 8'h00);
  endtask

  task automatic dwrite(input string rq, input logic [7:0] d, input int spw, input int hold);
    access(rq, 1'b1, A_DATA, {24'hEE_EE_EE, d}, 32'd0, 1'b0, spw + hold + 4, 1,
           spw + 1, spw + 1 + hold + 2, d);
  endtask

  task automatic dread(input string rq, input logic [7:0] b, input int spw, input int lat);
    nand_dq_i = b;
    access(rq, 1'b0, A_DATA, 32'd0, {24'b0, b}, 1'b1, lat, 2, spw + 1, 0, 8'h00);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ce_n idle", {28'b0, nand_ce_n}, 32'hF);
    check("R1 strobes idle", {30'b0, nand_we_n, nand_re_n}, 32'h3);
    check("R1 no drive", {31'b0, nand_dq_oe}, 32'h0);
    rreg("R1 mode default", A_MODE, 32'h0);
    rreg("R1 timing default", A_TIME, 32'hFF);
    rreg("R1 srst default", A_SRST, 32'h0);
    rreg("R7 status idle", A_STAT, 32'h0);

    // R5 timing register
    wreg("R5 timing write", A_TIME, 32'hABCD_0021);
    rreg("R5 timing readback", A_TIME, 32'h21);

    // R10 unmapped offsets
    wreg("R10 write 0x0C", 5'h0C, 32'hFFFF_FFFF);
    rreg("R10 read 0x0C", 5'h0C, 32'h0);
    rreg("R10 read 0x10", 5'h10, 32'h0);
    rreg("R10 read 0x1C", 5'h1C, 32'h0);
    rreg("R10 mode untouched", A_MODE, 32'h0);

    // R6 gated write: no strobe, ack after one clock
    access("R6 gated write", 1'b1, A_DATA, 32'hA5, 32'd0, 1'b0, 1, 0, 0, 0, 8'h00);
    check("R6 we_n stayed high", {31'b0, nand_we_n}, 32'h1);

    // R2 mode fields
    wreg("R2 mode write", A_MODE, 32'h9D);
    rreg("R2 mode readback", A_MODE, 32'h9D);
    check("R2 ce select 3", {28'b0, nand_ce_n}, 32'h7);
    check("R2 cle/ale", {30'b0, nand_cle, nand_ale}, 32'h2);
    wreg("R2 mode all ones", A_MODE, 32'hFFFF_FFFF);
    rreg("R2 spare bits read 0", A_MODE, 32'h9F);
    check("R2 ale on", {31'b0, nand_ale}, 32'h1);
    wreg("R2 select 1", A_MODE, 32'h14);
    check("R2 ce select 1", {28'b0, nand_ce_n}, 32'hD);
    wreg("R2 select 2 disabled", A_MODE, 32'h08);
    check("R2 ce disabled", {28'b0, nand_ce_n}, 32'hF);

    // R3 data writes
    wreg("R3 gate on", A_MODE, 32'h90);
    check("R3 ce select 0", {28'b0, nand_ce_n}, 32'hE);
    dwrite("R3 write spw1 hold2", 8'h3C, 1, 2);
    wreg("R3 timing zero", A_TIME, 32'h00);
    dwrite("R3 write spw0 hold0", 8'h5A, 0, 0);

    // R6 command write permitted by CLE alone
    wreg("R6 cle only", A_MODE, 32'h11);
    check("R6 cle pin", {31'b0, nand_cle}, 32'h1);
    dwrite("R6 command write", 8'h70, 0, 0);

    // R4 data read
    wreg("R4 mode", A_MODE, 32'h10);
    wreg("R4 timing", A_TIME, 32'h53);
    dread("R4 read spw3 hold5", 8'hC3, 3, 12);

    // R7 busy flag
    nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    rreg("R7 status busy", A_STAT, 32'h80);
    nand_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    rreg("R7 status ready", A_STAT, 32'h0);

    // R8 soft reset
    wreg("R8 mode before", A_MODE, 32'h9D);
    wreg("R8 reset write", A_SRST, 32'h1);
    rreg("R8 reset bit set", A_SRST, 32'h1);
    wreg("R8 write in window", A_MODE, 32'h80);
    repeat (6) @(negedge clk);
    rreg("R8 reset bit clear", A_SRST, 32'h0);
    rreg("R8 mode restored", A_MODE, 32'h0);
    rreg("R8 timing restored", A_TIME, 32'hFF);
    check("R8 ce released", {28'b0, nand_ce_n}, 32'hF);
    wreg("R8 reset again", A_SRST, 32'h1);
    dread("R8 stalled read", 8'h6E, 15, 37);
    dread("R4 read default timing", 8'h01, 15, 34);

    repeat (4) @(negedge clk);
    check("R9 no pending items", sbq.size(), 32'd0);
    done = 1;
    summary();
  end
endmodule